// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the command bus of a single-rank, four-bank SDRAM from reset until the device can take normal traffic. It first keeps the bus quiet for a programmable settling time and then precharges every bank. Next it issues a programmable number of auto-refresh commands and writes the mode register. Only after the last required spacing has passed does it raise a done flag, so the rest of the memory controller knows it may take over the bus.

The controller is a single state machine with eight states. ST_QUIET counts down the settling time and goes to ST_PRECHARGE when the shared timer expires. ST_PRECHARGE always moves on to ST_WAIT_RP, which goes to ST_REFRESH on timer expiry. ST_REFRESH always moves on to ST_WAIT_RFC. On expiry, ST_WAIT_RFC returns to ST_REFRESH while refreshes remain, and otherwise goes to ST_LOAD_MODE. ST_LOAD_MODE always moves on to ST_WAIT_MRD, which goes to ST_READY on expiry. ST_READY holds until reset. One shared down-counter times the settling period and every gap. A registered output stage turns the state into bus levels, so every pin changes just after a rising clock edge.

Commands are the 4-bit value {CS#, RAS#, CAS#, WE#}: inhibit 1111, NOP 0111, precharge 0010, auto refresh 0001, load mode 0000. In the cycle counts below, cycle k is the clock period that follows the k-th rising edge after reset is released.

Top module: `sdram_init_seq`

## Requirements
- R1: CKE and DQM are high during reset and in every cycle after it.
- R2: While reset is held, the bus carries command inhibit (CS# = 1) and done is low. After release, cycles 1 to WAIT_CYCLES carry NOP (0111), and the precharge appears in cycle WAIT_CYCLES+1.
- R3: Exactly one precharge (0010) is issued. It has address bit A10 = 1, all other address bits 0 and bank address 0, so it reaches every bank.
- R4: Exactly NUM_REFRESH auto-refresh commands (0001) follow the precharge, with address and bank address 0. NUM_REFRESH is at least 2.
- R5: Exactly one load-mode command (0000) follows the last refresh. It has the address bus equal to MODE_VALUE and bank address 0. The default 12'h030 means sequential burst, burst length 1 and CAS latency 3.
- R6: The first refresh comes exactly T_RP cycles after the precharge. Each later refresh, and the load-mode command, comes exactly T_RFC cycles after the refresh before it. Every cycle between commands carries NOP. All gap parameters are at least 2.
- R7: Done rises exactly T_MRD cycles after the load-mode command. It then stays high, with the bus on NOP, until the next reset. A reset at any point restarts the whole sequence from R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising-edge active |
| rst | input | 1 | Synchronous active-high reset |
| cke_o | output | 1 | Clock enable to the device |
| dqm_o | output | 1 | Data mask to the device |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | BA_W | Bank address |
| addr_o | output | ADDR_W | Address bus |
| init_done_o | output | 1 | Initialization complete, sticky until reset |

## Verification
The in-RTL assertions check the local rules on every cycle:
- the precharge leaves ST_QUIET only after the timer has expired;
- the refresh count has been reached when the load-mode state is entered;
- a precharge carries A10 high and bank address zero;
- every command is followed by a NOP;
- done only rises after a mode load, stays high, and implies a quiet bus.

The exact cycle of each command, the total number of each command type, the mode value on the bus and the restart after a reset at every point of the sequence can only be shown by the bench's recorded command trace.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    typedef enum logic [2:0] {
        ST_QUIET,
        ST_PRECHARGE,
        ST_WAIT_RP,
        ST_REFRESH,
        ST_WAIT_RFC,
        ST_LOAD_MODE,
        ST_WAIT_MRD,
        ST_READY
    } init_state_t;

    // {cs_n, ras_n, cas_n, we_n}
    typedef logic [3:0] bus_cmd_t;

    localparam bus_cmd_t CMD_INHIBIT   = 4'b1111;
    localparam bus_cmd_t CMD_NOP       = 4'b0111;
    localparam bus_cmd_t CMD_PRECHARGE = 4'b0010;
    localparam bus_cmd_t CMD_REFRESH   = 4'b0001;
    localparam bus_cmd_t CMD_LOAD_MODE = 4'b0000;

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
    parameter int unsigned CNT_W     = 14,
    parameter int unsigned RESET_VAL = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= CNT_W'(RESET_VAL);
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
    import sdram_init_pkg::*;
#(
    parameter int unsigned CNT_W       = 14,
    parameter int unsigned NUM_REFRESH = 2,
    parameter int unsigned RP_LOAD     = 1,
    parameter int unsigned RFC_LOAD    = 8,
    parameter int unsigned MRD_LOAD    = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             timer_expired,
    output init_state_t      state_o,
    output logic             timer_load,
    output logic [CNT_W-1:0] timer_load_val
);

    localparam int unsigned REF_W = $clog2(NUM_REFRESH + 1);
    localparam logic [REF_W-1:0] REF_LAST = REF_W'(NUM_REFRESH);

    init_state_t      state_q, state_d;
    logic [REF_W-1:0] ref_cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_cnt_q <= '0;
        end else if (state_q == ST_REFRESH) begin
            ref_cnt_q <= ref_cnt_q + 1'b1;
        end
    end

    always_comb begin
        state_d        = state_q;
        timer_load     = 1'b0;
        timer_load_val = '0;
        unique case (state_q)
            ST_QUIET: begin
                if (timer_expired) state_d = ST_PRECHARGE;
            end
            ST_PRECHARGE: begin
                state_d        = ST_WAIT_RP;
                timer_load     = 1'b1;
                timer_load_val = CNT_W'(RP_LOAD);
            end
            ST_WAIT_RP: begin
                if (timer_expired) state_d = ST_REFRESH;
            end
            ST_REFRESH: begin
                state_d        = ST_WAIT_RFC;
                timer_load     = 1'b1;
                timer_load_val = CNT_W'(RFC_LOAD);
            end
            ST_WAIT_RFC: begin
                if (timer_expired) begin
                    state_d = (ref_cnt_q == REF_LAST) ? ST_LOAD_MODE : ST_REFRESH;
                end
            end
            ST_LOAD_MODE: begin
                state_d        = ST_WAIT_MRD;
                timer_load     = 1'b1;
                timer_load_val = CNT_W'(MRD_LOAD);
            end
            ST_WAIT_MRD: begin
                if (timer_expired) state_d = ST_READY;
            end
            ST_READY: begin
                state_d = ST_READY;
            end
        endcase
    end

    assign state_o = state_q;

    // R2
    quiet_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PRECHARGE) |-> $past(timer_expired));

    // R4
    refresh_count_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LOAD_MODE) |-> (ref_cnt_q == REF_LAST));

endmodule

// File: rtl/sdram_init_cmd_drive.sv
module sdram_init_cmd_drive
    import sdram_init_pkg::*;
#(
    parameter int unsigned ADDR_W     = 12,
    parameter int unsigned BA_W       = 2,
    parameter int unsigned AP_BIT     = 10,
    parameter logic [ADDR_W-1:0] MODE_VALUE = 12'h030
) (
    input  logic              clk,
    input  logic              rst,
    input  init_state_t       state_i,
    output logic              cke_o,
    output logic              dqm_o,
    output bus_cmd_t          cmd_o,
    output logic [BA_W-1:0]   ba_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              done_o
);

    localparam logic [ADDR_W-1:0] PRE_ALL_ADDR = ADDR_W'(1) << AP_BIT;

    bus_cmd_t          cmd_d, cmd_q;
    logic [ADDR_W-1:0] addr_d, addr_q;
    logic              done_d, done_q;
    logic [BA_W-1:0]   ba_q;
    logic              cke_q, dqm_q;

    always_comb begin
        cmd_d  = CMD_NOP;
        addr_d = '0;
        done_d = 1'b0;
        unique case (state_i)
            ST_PRECHARGE: begin
                cmd_d  = CMD_PRECHARGE;
                addr_d = PRE_ALL_ADDR;
            end
            ST_REFRESH:   cmd_d = CMD_REFRESH;
            ST_LOAD_MODE: begin
                cmd_d  = CMD_LOAD_MODE;
                addr_d = MODE_VALUE;
            end
            ST_READY:     done_d = 1'b1;
            ST_QUIET, ST_WAIT_RP, ST_WAIT_RFC, ST_WAIT_MRD: cmd_d = CMD_NOP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= CMD_INHIBIT;
            addr_q <= '0;
            ba_q   <= '0;
            done_q <= 1'b0;
            cke_q  <= 1'b1;
            dqm_q  <= 1'b1;
        end else begin
            cmd_q  <= cmd_d;
            addr_q <= addr_d;
            ba_q   <= '0;
            done_q <= done_d;
            cke_q  <= 1'b1;
            dqm_q  <= 1'b1;
        end
    end

    assign cmd_o  = cmd_q;
    assign addr_o = addr_q;
    assign ba_o   = ba_q;
    assign done_o = done_q;
    assign cke_o  = cke_q;
    assign dqm_o  = dqm_q;

    // R3
    precharge_all_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_q == CMD_PRECHARGE) |-> (addr_q[AP_BIT] && ba_q == '0));

    // R6
    cmd_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_q != CMD_NOP) |=> (cmd_q == CMD_NOP));

    // R7
    done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |=> done_q);

    // R7
    done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (cmd_q == CMD_NOP));

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int unsigned WAIT_CYCLES = 14300,
    parameter int unsigned T_RP        = 3,
    parameter int unsigned T_RFC       = 10,
    parameter int unsigned T_MRD       = 2,
    parameter int unsigned NUM_REFRESH = 2,
    parameter int unsigned ADDR_W      = 12,
    parameter int unsigned BA_W        = 2,
    parameter logic [ADDR_W-1:0] MODE_VALUE = 12'h030
) (
    input  logic              clk,
    input  logic              rst,
    output logic              cke_o,
    output logic              dqm_o,
    output logic              cs_n_o,
    output logic              ras_n_o,
    output logic              cas_n_o,
    output logic              we_n_o,
    output logic [BA_W-1:0]   ba_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              init_done_o
);

    localparam int unsigned MAX_GAP  = (T_RP > T_RFC) ? ((T_RP > T_MRD) ? T_RP : T_MRD)
                                                      : ((T_RFC > T_MRD) ? T_RFC : T_MRD);
    localparam int unsigned MAX_CNT  = (WAIT_CYCLES > MAX_GAP) ? WAIT_CYCLES : MAX_GAP;
    localparam int unsigned CNT_W    = $clog2(MAX_CNT + 1);
    localparam int unsigned QUIET_LD = (WAIT_CYCLES < 1) ? 0 : WAIT_CYCLES - 1;
    localparam int unsigned RP_LD    = (T_RP  < 2) ? 0 : T_RP  - 2;
    localparam int unsigned RFC_LD   = (T_RFC < 2) ? 0 : T_RFC - 2;
    localparam int unsigned MRD_LD   = (T_MRD < 2) ? 0 : T_MRD - 2;

    init_state_t      state;
    logic             timer_expired;
    logic             timer_load;
    logic [CNT_W-1:0] timer_load_val;
    bus_cmd_t         bus_cmd;

    sdram_init_timer #(
        .CNT_W     (CNT_W),
        .RESET_VAL (QUIET_LD)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (timer_load),
        .load_val (timer_load_val),
        .expired  (timer_expired)
    );

    sdram_init_fsm #(
        .CNT_W       (CNT_W),
        .NUM_REFRESH (NUM_REFRESH),
        .RP_LOAD     (RP_LD),
        .RFC_LOAD    (RFC_LD),
        .MRD_LOAD    (MRD_LD)
    ) u_fsm (
        .clk            (clk),
        .rst            (rst),
        .timer_expired  (timer_expired),
        .state_o        (state),
        .timer_load     (timer_load),
        .timer_load_val (timer_load_val)
    );

    sdram_init_cmd_drive #(
        .ADDR_W     (ADDR_W),
        .BA_W       (BA_W),
        .AP_BIT     (10),
        .MODE_VALUE (MODE_VALUE)
    ) u_drive (
        .clk     (clk),
        .rst     (rst),
        .state_i (state),
        .cke_o   (cke_o),
        .dqm_o   (dqm_o),
        .cmd_o   (bus_cmd),
        .ba_o    (ba_o),
        .addr_o  (addr_o),
        .done_o  (init_done_o)
    );

    assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = bus_cmd;

    logic mode_loaded_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_loaded_q <= 1'b0;
        end else if (bus_cmd == CMD_LOAD_MODE) begin
            mode_loaded_q <= 1'b1;
        end
    end

    // R5
    done_after_mode_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(init_done_o) |-> mode_loaded_q);

endmodule

// File: tb/sdram_init_seq_test.sv
module sdram_init_seq_test;

    localparam int CLK_PERIOD = 10;
    localparam int W     = 40;
    localparam int TRP   = 3;
    localparam int TRFC  = 5;
    localparam int TMRD  = 2;
    localparam int NREF  = 2;
    localparam logic [11:0] MODE = 12'h232;

    localparam int T_PRE  = W + 1;
    localparam int T_REF0 = T_PRE + TRP;
    localparam int T_LMR  = T_REF0 + NREF * TRFC;
    localparam int T_DONE = T_LMR + TMRD;
    localparam int T_END  = T_DONE + 12;
    localparam int NEV    = 2 + NREF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cke, dqm, cs_n, ras_n, cas_n, we_n, done;
    logic [1:0]  ba;
    logic [11:0] addr;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sdram_init_seq #(
        .WAIT_CYCLES (W),
        .T_RP        (TRP),
        .T_RFC       (TRFC),
        .T_MRD       (TMRD),
        .NUM_REFRESH (NREF),
        .ADDR_W      (12),
        .BA_W        (2),
        .MODE_VALUE  (MODE)
    ) uut (
        .clk         (clk),
        .rst         (rst),
        .cke_o       (cke),
        .dqm_o       (dqm),
        .cs_n_o      (cs_n),
        .ras_n_o     (ras_n),
        .cas_n_o     (cas_n),
        .we_n_o      (we_n),
        .ba_o        (ba),
        .addr_o      (addr),
        .init_done_o (done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(cke && dqm, "R1", "cke/dqm in reset", int'({cke, dqm}), 3);
        check(cs_n == 1'b1, "R2", "inhibit in reset", int'(cs_n), 1);
        check(done == 1'b0, "R2", "done in reset", int'(done), 0);
        rst = 1'b0;
    endtask

    task automatic full_run();
        int          ev_stamp[NEV + 4];
        logic [3:0]  ev_cmd[NEV + 4];
        logic [11:0] ev_addr[NEV + 4];
        logic [1:0]  ev_ba[NEV + 4];
        int          ev_n = 0;
        int          done_at = -1;
        int          done_drop = 0;
        int          cke_bad = 0;
        int          gap_bad = 0;
        logic [3:0]  c;
        do_reset();
        for (int k = 1; k <= T_END; k++) begin
            @(posedge clk);
            @(negedge clk);
            c = {cs_n, ras_n, cas_n, we_n};
            if (!(cke && dqm)) cke_bad++;
            if (c == 4'b0010 || c == 4'b0001 || c == 4'b0000) begin
                if (ev_n < NEV + 4) begin
                    ev_stamp[ev_n] = k;
                    ev_cmd[ev_n]   = c;
                    ev_addr[ev_n]  = addr;
                    ev_ba[ev_n]    = ba;
                end
                ev_n++;
            end else if (c != 4'b0111) begin
                gap_bad++;
            end
            if (done && done_at < 0) done_at = k;
            if (!done && done_at >= 0) done_drop++;
        end
        check(cke_bad == 0, "R1", "cke/dqm low cycles", cke_bad, 0);
        check(gap_bad == 0, "R6", "non-NOP idle cycles", gap_bad, 0);
        check(ev_n == NEV, "R4", "command count", ev_n, NEV);
        if (ev_n >= NEV) begin
            check(ev_cmd[0] == 4'b0010, "R3", "first command", int'(ev_cmd[0]), 2);
            check(ev_stamp[0] == T_PRE, "R2", "precharge cycle", ev_stamp[0], T_PRE);
            check(ev_addr[0] == 12'h400, "R3", "precharge addr", int'(ev_addr[0]), 'h400);
            check(ev_ba[0] == 2'd0, "R3", "precharge bank", int'(ev_ba[0]), 0);
            for (int i = 0; i < NREF; i++) begin
                check(ev_cmd[1 + i] == 4'b0001, "R4", "refresh command", int'(ev_cmd[1 + i]), 1);
                check(ev_addr[1 + i] == 12'h000 && ev_ba[1 + i] == 2'd0, "R4", "refresh addr",
                      int'(ev_addr[1 + i]), 0);
                check(ev_stamp[1 + i] == T_REF0 + i * TRFC, "R6", "refresh cycle",
                      ev_stamp[1 + i], T_REF0 + i * TRFC);
            end
            check(ev_cmd[NEV - 1] == 4'b0000, "R5", "load mode command", int'(ev_cmd[NEV - 1]), 0);
            check(ev_addr[NEV - 1] == MODE, "R5", "mode value", int'(ev_addr[NEV - 1]), int'(MODE));
            check(ev_ba[NEV - 1] == 2'd0, "R5", "mode bank", int'(ev_ba[NEV - 1]), 0);
            check(ev_stamp[NEV - 1] == T_LMR, "R6", "load mode cycle", ev_stamp[NEV - 1], T_LMR);
        end
        check(done_at == T_DONE, "R7", "done cycle", done_at, T_DONE);
        check(done_drop == 0, "R7", "done drops", done_drop, 0);
    endtask

    // R7: reset at every point of the sequence restarts it
    task automatic abort_sweep();
        for (int a = 1; a <= T_DONE + 1; a++) begin
            do_reset();
            repeat (a) @(posedge clk);
            @(negedge clk);
            rst = 1'b1;
            @(posedge clk);
            @(negedge clk);
            check(cs_n == 1'b1, "R7", "inhibit after abort", int'(cs_n), 1);
            check(done == 1'b0, "R7", "done after abort", int'(done), 0);
            check(cke && dqm, "R1", "cke/dqm after abort", int'({cke, dqm}), 3);
        end
    endtask

    initial begin
        full_run();
        abort_sweep();
        full_run();
        full_run();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        tests++;
        fails++;
        $display("FAIL R7 watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule